// File: doc/BRIEF.md
# Embedded-Sync Active Video Extractor

This block receives a digital video stream whose line and field timing is carried inside the data itself as timing reference codes. It searches the incoming words for a reference code, reads the field, vertical-blanking and line-position flags from the status word that ends each code, and forwards only the samples of active picture lines. Horizontal blanking, vertical-blanking lines and every word that belongs to a reference code are removed from the output.

The stream can be 10 bits wide, or 8 bits wide carried on the low byte of the input bus. The choice is made with a pin that is meant to change only while the block is held in reset. The output is a sample stream with a valid strobe and two markers: one marks the first sample of each active line and one marks the first sample after a field change. A reference code is only known once its fourth word arrives. The block therefore holds three words in a short delay line so that a code's leading words can be withdrawn. This gives a fixed latency of four clock edges from input to output.

Top module: `vid_active_extract`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, `pix_valid`, `pix_sol`, `pix_sof` and `pix_data` are all zero. The stored field flag resets to 0, and the block resets to being outside an active line.
- R2: A timing reference is four consecutive words: all-ones (0x3FF in 10-bit mode, 0xFF in 8-bit mode), zero, zero, then a status word. Matching uses only the active width.
- R3: Status word flags: in 10-bit mode F is bit 8, V is bit 7 and H is bit 6. In 8-bit mode F is bit 6, V is bit 5 and H is bit 4. H=0 is a start-of-active-video code and H=1 is an end-of-active-video code.
- R4: Samples after a start-of-active-video code with V=0 are forwarded until the next reference code. A word sampled at clock edge k appears on `pix_data` with `pix_valid` high after edge k+3.
- R5: No sample is forwarded between an end-of-active-video code and the next start-of-active-video code.
- R6: After a start-of-active-video code with V=1, no sample is forwarded until a start-of-active-video code with V=0.
- R7: The four words of a timing reference are never forwarded, including a reference that arrives in the middle of an active line.
- R8: A partial reference (all-ones, or all-ones then zero, followed by a word that breaks the pattern) is ordinary data and is forwarded when inside an active line.
- R9: `pix_sol` is high on the first forwarded sample after each start-of-active-video code with V=0.
- R10: A status word whose F differs from the stored field flag arms a marker. `pix_sof` is high on the next forwarded sample. `pix_sof` implies `pix_sol`.
- R11: In 8-bit mode `din[9:8]` has no effect, and `pix_data[9:8]` is zero.
- R12: When `pix_valid` is low, `pix_data`, `pix_sol` and `pix_sof` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one word per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 = 10-bit stream, 0 = 8-bit stream on din[7:0] |
| din | input | 10 | Incoming video word |
| pix_data | output | 10 | Forwarded active sample |
| pix_valid | output | 1 | pix_data holds an active sample |
| pix_sol | output | 1 | First sample of an active line |
| pix_sof | output | 1 | First sample after a field flag change |

## Verification
The bench targets several corner cases, each with a distinct failure mode:
- An end-of-active-video code arriving mid-line. A design that forwards as soon as it sees data would leak the three leading code words onto the output.
- Partial codes such as all-ones then zero then data, and double all-ones. A detector that does not fall back to search would swallow these words or lock onto a false code.
- A start-of-active-video code with V=1. A design that ignores the vertical flag would emit blanking-line data.
- A field toggle. A misplaced field marker would land on the wrong sample.
- 8-bit operation with junk on the upper input bits. A design that fails to mask them would miss codes or leak the junk into the output.

// File: rtl/vae_pkg.sv
package vae_pkg;

   // per-sample forwarding tag carried through the delay line
   typedef struct packed {
      logic fwd;
      logic sol;
      logic sof;
   } vae_tag_t;

   localparam vae_tag_t VAE_TAG_NONE = '{fwd: 1'b0, sol: 1'b0, sof: 1'b0};

   // flags decoded from a status word
   typedef struct packed {
      logic f;
      logic v;
      logic h;
   } vae_status_t;

endpackage

// File: rtl/vae_word_class.sv
module vae_word_class
   import vae_pkg::*;
#(
   parameter int unsigned NARROW_W = 8,
   parameter int unsigned WIDE_W   = 10
) (
   input  logic              wide_mode,
   input  logic [WIDE_W-1:0] din,
   output logic [WIDE_W-1:0] word,
   output logic              all_ones,
   output logic              all_zeros,
   output vae_status_t       status
);

   localparam int unsigned PAD_W = WIDE_W - NARROW_W;
   localparam logic [WIDE_W-1:0] NARROW_MASK = {{PAD_W{1'b0}}, {NARROW_W{1'b1}}};

   generate
      if (NARROW_W < 4) begin : g_bad_narrow
         $error("vae_word_class: NARROW_W must be at least 4");
      end
      if (WIDE_W <= NARROW_W) begin : g_bad_wide
         $error("vae_word_class: WIDE_W must exceed NARROW_W");
      end
   endgenerate

   always_comb begin
      word      = wide_mode ? din : (din & NARROW_MASK);
      all_ones  = wide_mode ? (&din) : (&din[NARROW_W-1:0]);
      all_zeros = (word == '0);
      if (wide_mode) begin
         status.f = din[WIDE_W-2];
         status.v = din[WIDE_W-3];
         status.h = din[WIDE_W-4];
      end else begin
         status.f = din[NARROW_W-2];
         status.v = din[NARROW_W-3];
         status.h = din[NARROW_W-4];
      end
   end

endmodule

// File: rtl/vae_trs_window.sv
module vae_trs_window
   import vae_pkg::*;
#(
   parameter int unsigned WIDE_W   = 10,
   parameter int unsigned LEAD_LEN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDE_W-1:0] in_word,
   input  logic              in_ones,
   input  logic              in_zeros,
   input  vae_tag_t          in_tag,
   output logic              trs_hit,
   output logic [WIDE_W-1:0] tail_word,
   output vae_tag_t          tail_tag
);

   localparam int unsigned LAST = LEAD_LEN - 1;

   generate
      if (LEAD_LEN < 2) begin : g_bad_lead
         $error("vae_trs_window: LEAD_LEN must be at least 2");
      end
   endgenerate

   logic [WIDE_W-1:0] word_q  [LEAD_LEN];
   vae_tag_t          tag_q   [LEAD_LEN];
   logic [LEAD_LEN-1:0] ones_q;
   logic [LEAD_LEN-1:0] zeros_q;
   logic [LEAD_LEN-1:0] match;

   // oldest slot must be all-ones, every newer slot all-zeros
   generate
      for (genvar g = 0; g < LEAD_LEN; g++) begin : g_match
         if (g == LAST) begin : g_lead
            assign match[g] = ones_q[g];
         end else begin : g_zero
            assign match[g] = zeros_q[g];
         end
      end
   endgenerate

   assign trs_hit   = &match;
   assign tail_word = word_q[LAST];
   assign tail_tag  = tag_q[LAST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q  <= '0;
         zeros_q <= '0;
         for (int i = 0; i < LEAD_LEN; i++) begin
            word_q[i] <= '0;
            tag_q[i]  <= VAE_TAG_NONE;
         end
      end else begin
         word_q[0]  <= in_word;
         tag_q[0]   <= in_tag;
         ones_q[0]  <= in_ones;
         zeros_q[0] <= in_zeros;
         for (int i = 1; i < LEAD_LEN; i++) begin
            word_q[i]  <= word_q[i-1];
            ones_q[i]  <= ones_q[i-1];
            zeros_q[i] <= zeros_q[i-1];
            // words that formed a reference code are withdrawn
            tag_q[i]   <= trs_hit ? VAE_TAG_NONE : tag_q[i-1];
         end
      end
   end

endmodule

// File: rtl/vae_sync_tracker.sv
module vae_sync_tracker
   import vae_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        trs_hit,
   input  vae_status_t status,
   output vae_tag_t    entry_tag
);

   logic field_q;
   logic line_open_q;
   logic sol_pend_q;
   logic sof_pend_q;

   always_comb begin
      entry_tag.fwd = line_open_q & ~trs_hit;
      entry_tag.sol = entry_tag.fwd & sol_pend_q;
      entry_tag.sof = entry_tag.fwd & sof_pend_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         field_q     <= 1'b0;
         line_open_q <= 1'b0;
         sol_pend_q  <= 1'b0;
         sof_pend_q  <= 1'b0;
      end else if (trs_hit) begin
         field_q <= status.f;
         if (status.f != field_q) begin
            sof_pend_q <= 1'b1;
         end
         if (!status.h) begin
            line_open_q <= ~status.v;
            if (!status.v) begin
               sol_pend_q <= 1'b1;
            end
         end else begin
            line_open_q <= 1'b0;
         end
      end else if (entry_tag.fwd) begin
         sol_pend_q <= 1'b0;
         sof_pend_q <= 1'b0;
      end
   end

endmodule

// File: rtl/vid_active_extract.sv
module vid_active_extract
   import vae_pkg::*;
#(
   parameter int unsigned NARROW_W = 8,
   parameter int unsigned WIDE_W   = 10,
   parameter int unsigned LEAD_LEN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_mode,
   input  logic [WIDE_W-1:0] din,
   output logic [WIDE_W-1:0] pix_data,
   output logic              pix_valid,
   output logic              pix_sol,
   output logic              pix_sof
);

   logic [WIDE_W-1:0] cls_word;
   logic              cls_ones;
   logic              cls_zeros;
   vae_status_t       cls_status;
   vae_tag_t          entry_tag;
   logic              trs_hit;
   logic [WIDE_W-1:0] tail_word;
   vae_tag_t          tail_tag;
   logic              emit;

   vae_word_class #(
      .NARROW_W (NARROW_W),
      .WIDE_W   (WIDE_W)
   ) u_class (
      .wide_mode (wide_mode),
      .din       (din),
      .word      (cls_word),
      .all_ones  (cls_ones),
      .all_zeros (cls_zeros),
      .status    (cls_status)
   );

   vae_sync_tracker u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .trs_hit   (trs_hit),
      .status    (cls_status),
      .entry_tag (entry_tag)
   );

   vae_trs_window #(
      .WIDE_W   (WIDE_W),
      .LEAD_LEN (LEAD_LEN)
   ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_word   (cls_word),
      .in_ones   (cls_ones),
      .in_zeros  (cls_zeros),
      .in_tag    (entry_tag),
      .trs_hit   (trs_hit),
      .tail_word (tail_word),
      .tail_tag  (tail_tag)
   );

   assign emit = tail_tag.fwd & ~trs_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_data  <= '0;
         pix_valid <= 1'b0;
         pix_sol   <= 1'b0;
         pix_sof   <= 1'b0;
      end else begin
         pix_valid <= emit;
         pix_data  <= emit ? tail_word : '0;
         pix_sol   <= emit & tail_tag.sol;
         pix_sof   <= emit & tail_tag.sof;
      end
   end

endmodule

// File: rtl/vae_active_extract_chk.sv
module vae_active_extract_chk #(
   parameter int unsigned NARROW_W = 8,
   parameter int unsigned WIDE_W   = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wide_mode,
   input logic [WIDE_W-1:0] din,
   input logic [WIDE_W-1:0] pix_data,
   input logic              pix_valid,
   input logic              pix_sol,
   input logic              pix_sof
);

   localparam logic [WIDE_W-1:0] LOW_MASK = {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

   // edges seen since reset, so history checks never reach before it
   logic [2:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (age != 3'd7) age <= age + 3'd1;
   end

   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |-> (pix_data == '0 && !pix_sol && !pix_sof));

   // R10
   sof_on_line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_sof |-> (pix_sol && pix_valid));

   // R4
   fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 3'd5 && pix_valid) |->
         (pix_data == ($past(wide_mode, 4) ? $past(din, 4) : ($past(din, 4) & LOW_MASK))));

   // R11
   narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 3'd5 && !$past(wide_mode, 4)) |-> ((pix_data & ~LOW_MASK) == '0));

endmodule

bind vid_active_extract vae_active_extract_chk #(
   .NARROW_W (NARROW_W),
   .WIDE_W   (WIDE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wide_mode (wide_mode),
   .din       (din),
   .pix_data  (pix_data),
   .pix_valid (pix_valid),
   .pix_sol   (pix_sol),
   .pix_sof   (pix_sof)
);

// File: tb/vid_active_extract_test.sv
module vid_active_extract_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wide_mode = 1'b1;
   logic [9:0] din = '0;
   logic [9:0] pix_data;
   logic       pix_valid, pix_sol, pix_sof;

   always #5 clk = ~clk;

   vid_active_extract uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wide_mode (wide_mode),
      .din       (din),
      .pix_data  (pix_data),
      .pix_valid (pix_valid),
      .pix_sol   (pix_sol),
      .pix_sof   (pix_sof)
   );

   int    vectors = 0;
   int    errors  = 0;
   string cur_req = "R1";
   bit    done    = 1'b0;
   logic [1:0] junk = 2'b00;

   // ---------------- reference model ----------------
   typedef struct {
      bit         fwd;
      bit         sol;
      bit         sof;
      logic [9:0] w;
   } rec_t;

   rec_t       pend[$];
   logic [9:0] hist[$];
   bit         m_act, m_field, m_solp, m_sofp;
   rec_t       expo = '{1'b0, 1'b0, 1'b0, 10'h000};

   task automatic model_step();
      logic [9:0] n;
      bit         det, f, v, h;
      rec_t       r;
      rec_t       o;
      n   = wide_mode ? din : {2'b00, din[7:0]};
      det = (hist.size() == 3) && (hist[0] == (wide_mode ? 10'h3FF : 10'h0FF))
            && (hist[1] == 10'h000) && (hist[2] == 10'h000);
      r = '{1'b0, 1'b0, 1'b0, n};
      if (det) begin
         foreach (pend[i]) begin
            pend[i].fwd = 1'b0;
            pend[i].sol = 1'b0;
            pend[i].sof = 1'b0;
         end
         f = wide_mode ? din[8] : din[6];
         v = wide_mode ? din[7] : din[5];
         h = wide_mode ? din[6] : din[4];
         if (f != m_field) m_sofp = 1'b1;
         m_field = f;
         if (!h) begin
            m_act = !v;
            if (!v) m_solp = 1'b1;
         end else begin
            m_act = 1'b0;
         end
      end else begin
         r.fwd = m_act;
         r.sol = m_act && m_solp;
         r.sof = m_act && m_sofp;
         if (m_act) begin
            m_solp = 1'b0;
            m_sofp = 1'b0;
         end
      end
      o = '{1'b0, 1'b0, 1'b0, 10'h000};
      if (pend.size() == 3) o = pend.pop_front();
      expo = o;
      pend.push_back(r);
      hist.push_back(n);
      if (hist.size() > 3) void'(hist.pop_front());
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend.delete();
         hist.delete();
         m_act = 1'b0; m_field = 1'b0; m_solp = 1'b0; m_sofp = 1'b0;
         expo = '{1'b0, 1'b0, 1'b0, 10'h000};
      end else begin
         model_step();
      end
   end

   // ---------------- comparison on every cycle ----------------
   always @(negedge clk) begin
      logic [9:0] ed;
      if (!done) begin
         ed = expo.fwd ? expo.w : 10'h000;
         vectors++;
         if (pix_valid !== expo.fwd || pix_data !== ed ||
             pix_sol !== expo.sol || pix_sof !== expo.sof) begin
            errors++;
            $display("FAIL %s: got valid=%0b data=%h sol=%0b sof=%0b, expected valid=%0b data=%h sol=%0b sof=%0b",
                     cur_req, pix_valid, pix_data, pix_sol, pix_sof,
                     expo.fwd, ed, expo.sol, expo.sof);
         end
      end
   end

   task automatic report();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got no completion, expected end within 200000 cycles");
         report();
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic word(input logic [9:0] v10, input logic [7:0] v8);
      @(negedge clk);
      if (wide_mode) din = v10;
      else begin
         junk = junk + 2'd1;
         din  = {junk, v8};
      end
   endtask

   task automatic trs(input bit f, input bit v, input bit h);
      word(10'h3FF, 8'hFF);
      word(10'h000, 8'h00);
      word(10'h000, 8'h00);
      word({1'b1, f, v, h, 6'b000000}, {1'b1, f, v, h, 4'b0000});
   endtask

   task automatic active_data(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         logic [9:0] d;
         d = 10'((seed * 13 + i * 29 + 5) % 1024);
         word(d, d[7:0]);
      end
   endtask

   task automatic line(input bit f, input bit v, input int n, input int seed);
      trs(f, v, 1'b1);
      repeat (5) word(10'h200, 8'h80);
      trs(f, v, 1'b0);
      active_data(n, seed);
   endtask

   task automatic do_reset(input bit wide);
      @(posedge clk); #3 rst_n = 1'b0;
      wide_mode = wide;
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;
   endtask

   initial begin
      // R1: reset state, then idle after release
      cur_req = "R1";
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;
      repeat (4) word(10'h155, 8'h55);

      // R6: blanking lines with V=1 forward nothing
      cur_req = "R6";
      line(1'b0, 1'b1, 12, 1);
      line(1'b0, 1'b1, 12, 2);

      // R4 / R9 / R7: active lines, each closed by an end code mid-stream
      cur_req = "R4";
      line(1'b0, 1'b0, 16, 3);
      cur_req = "R9";
      line(1'b0, 1'b0, 9, 4);

      // R5: horizontal blanking after end code carries no output
      cur_req = "R5";
      trs(1'b0, 1'b0, 1'b1);
      repeat (10) word(10'h3FF, 8'hFF);
      repeat (3) word(10'h010, 8'h10);

      // R8: broken preambles inside an active line stay data
      cur_req = "R8";
      trs(1'b0, 1'b0, 1'b0);
      word(10'h3FF, 8'hFF); word(10'h000, 8'h00); word(10'h155, 8'h55);
      word(10'h3FF, 8'hFF); word(10'h3FF, 8'hFF); word(10'h000, 8'h00); word(10'h2AA, 8'hAA);
      word(10'h000, 8'h00); word(10'h000, 8'h00); word(10'h000, 8'h00); word(10'h011, 8'h11);

      // R7: end code arriving right after data
      cur_req = "R7";
      trs(1'b0, 1'b0, 1'b1);
      repeat (4) word(10'h200, 8'h80);

      // R10: field toggles to 1 through a blanking line, then back to 0
      cur_req = "R10";
      line(1'b1, 1'b1, 6, 5);
      line(1'b1, 1'b0, 8, 6);
      line(1'b1, 1'b0, 8, 7);
      line(1'b0, 1'b0, 8, 8);

      // R3: 8-bit mode with junk on upper bits; status bits at 6/5/4
      do_reset(1'b0);
      cur_req = "R3";
      line(1'b0, 1'b1, 6, 9);
      line(1'b0, 1'b0, 10, 10);
      cur_req = "R11";
      line(1'b1, 1'b0, 10, 11);
      cur_req = "R2";
      trs(1'b1, 1'b0, 1'b0);
      word(10'h0FF, 8'hFF); word(10'h000, 8'h00); word(10'h042, 8'h42);
      active_data(6, 12);
      trs(1'b1, 1'b0, 1'b1);

      // R12: quiet outputs while idle
      cur_req = "R12";
      repeat (8) word(10'h080, 8'h80);

      @(negedge clk);
      report();
      $finish;
   end

endmodule